// File: doc/BRIEF.md
# Per-Hop Credit Link Flow Controller

This block sits at one end of a point-to-point link in a chain of nodes that pass fixed-maximum-size data packets downstream. It does the flow control for one hop. The receive half parses incoming words into three message kinds. Data packets go into a packet buffer of `DEPTH` slots. Credit words refill the local transmit budget. Control words are handed straight to the local consumer.

Whenever the local consumer has read the final word of a buffered packet, that slot is free again. The block then returns exactly one single-word credit message to the sender over the same outgoing link that carries data.

The transmit half keeps a budget of packet credits, starting at `DEPTH`. It opens a new data packet only while that budget is non-zero. It shares the outgoing word stream among pending credit returns, local control words and data packets. Credit returns and control words never queue behind a stalled data source. A data packet that has started is always finished before anything else is sent.

Because backpressure is purely per hop, a stall stays local to the hop where it occurs. No stop signal is broadcast along the chain.

Top module: `link_credit_ctrl`

## Requirements
- R1: After synchronous reset, `link_valid`, `pkt_valid`, `ctl_rx_valid` and `tx_dat_ready` are 0, `ctl_in_ready` is 1, and the transmit budget holds `DEPTH` credits.
- R2: Word format on both link directions. Bits [31:30] give the kind: 00 is a data header, 01 is a credit, 10 is a control word.
  - A data header carries the packet length minus one in bits [3:0], with all other bits 0. It is followed by exactly that many payload words (1..16).
  - A credit word is 32'h4000_0000.
  - A control word carries its 30-bit payload in bits [29:0].
- R3: A data header is sent only while the transmit budget is non-zero. Each header sent takes one credit from the budget. With the budget at zero, a waiting packet stays unsent.
- R4: Each credit word received on `rx_word` adds one credit to the budget. The budget never rises above `DEPTH`, and extra credits are discarded.
- R5: Between packets, the outgoing link gives fixed priority to a pending credit return, then to a local control word, then to a new data packet.
- R6: Once a data header has been sent, all of its payload words are sent before any credit or control word.
- R7: A local control word is sent even when the transmit budget is zero and a data packet is waiting.
- R8: Received data packets are presented on `pkt_word` in arrival order, one word per `pkt_rd` read. `pkt_last` is 1 on the final word of each packet.
- R9: A buffer slot is released only when the final word of its packet is read. Each released slot produces exactly one credit word on the link, no earlier than the cycle after that read.
- R10: A received control word raises `ctl_rx_valid` for one cycle, in the cycle after it arrived, with its payload on `ctl_rx_payload`. Received credit and control words are never placed in the packet buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Incoming link word valid |
| rx_word | input | 32 | Incoming link word |
| link_valid | output | 1 | Outgoing link word valid |
| link_word | output | 32 | Outgoing link word |
| tx_dat_valid | input | 1 | Local data source has a word |
| tx_dat_lm1 | input | 4 | Packet length minus one, held from the first word of a packet |
| tx_dat_word | input | 32 | Local data payload word |
| tx_dat_ready | output | 1 | Payload word accepted at this edge |
| ctl_in_valid | input | 1 | Local control word request |
| ctl_in_payload | input | 30 | Local control payload |
| ctl_in_ready | output | 1 | Control word accepted at this edge |
| ctl_rx_valid | output | 1 | Received control word strobe |
| ctl_rx_payload | output | 30 | Received control payload |
| pkt_valid | output | 1 | Buffered packet word available |
| pkt_word | output | 32 | Current buffered packet word |
| pkt_last | output | 1 | Current word ends its packet |
| pkt_rd | input | 1 | Consume the current buffered word |

## Verification
The bench builds the block with `DEPTH` set to 2 and `MAXW` at 16. The small depth lets a few short packets drain the transmit budget. That brings within reach the zero-credit stall, saturation of the budget after surplus credits, and control traffic passing a blocked packet. The full 16-word slot width is kept, so header length decoding is exercised on the real field.

// File: rtl/lcc_pkg.sv
package lcc_pkg;

    typedef enum logic [1:0] {
        MSG_DATA   = 2'b00,
        MSG_CREDIT = 2'b01,
        MSG_CTRL   = 2'b10,
        MSG_RSVD   = 2'b11
    } msg_kind_e;

    localparam int LEN_FW = 4;

    typedef struct packed {
        logic        valid;
        logic [31:0] word;
    } link_beat_t;

    function automatic msg_kind_e kind_of(input logic [31:0] w);
        return msg_kind_e'(w[31:30]);
    endfunction

    function automatic logic [31:0] make_credit();
        return {MSG_CREDIT, 30'd0};
    endfunction

    function automatic logic [31:0] make_ctrl(input logic [29:0] p);
        return {MSG_CTRL, p};
    endfunction

    function automatic logic [31:0] make_hdr(input logic [LEN_FW-1:0] lm1);
        return {MSG_DATA, 26'd0, lm1};
    endfunction

endpackage

// File: rtl/lcc_rx_store.sv
module lcc_rx_store
    import lcc_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int MAXW  = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        rx_valid,
    input  logic [31:0] rx_word,
    output logic        credit_seen,
    output logic        ctl_valid,
    output logic [29:0] ctl_payload,
    output logic        pkt_valid,
    output logic [31:0] pkt_word,
    output logic        pkt_last,
    input  logic        pkt_rd,
    output logic        slot_freed
);
    localparam int IDX_W  = $clog2(MAXW);
    localparam int SLOT_W = $clog2(DEPTH);
    localparam int OCC_W  = $clog2(DEPTH + 1);
    localparam int LEFT_W = $clog2(MAXW + 1);
    localparam int ADDR_W = $clog2(DEPTH * MAXW);

    logic [31:0]       mem     [DEPTH*MAXW];
    logic [IDX_W-1:0]  slot_lm1[DEPTH];

    logic              in_body;
    logic [LEFT_W-1:0] left;
    logic [IDX_W-1:0]  widx, ridx;
    logic [SLOT_W-1:0] wslot, rslot;
    logic [OCC_W-1:0]  occ;

    msg_kind_e         kind;
    logic              hdr_in, body_in, wr_done, rd_fire, rd_last, ctl_in;
    logic [ADDR_W-1:0] waddr, raddr;

    function automatic logic [SLOT_W-1:0] next_slot(input logic [SLOT_W-1:0] s);
        return (s == SLOT_W'(DEPTH - 1)) ? '0 : s + 1'b1;
    endfunction

    always_comb begin
        kind        = kind_of(rx_word);
        hdr_in      = rx_valid && !in_body && (kind == MSG_DATA);
        credit_seen = rx_valid && !in_body && (kind == MSG_CREDIT);
        ctl_in      = rx_valid && !in_body && (kind == MSG_CTRL);
        body_in     = rx_valid && in_body;
        wr_done     = body_in && (left == LEFT_W'(1));
        waddr       = ADDR_W'(wslot) * ADDR_W'(MAXW) + ADDR_W'(widx);
        raddr       = ADDR_W'(rslot) * ADDR_W'(MAXW) + ADDR_W'(ridx);
        pkt_valid   = (occ != '0);
        pkt_word    = mem[raddr];
        rd_last     = (ridx == slot_lm1[rslot]);
        pkt_last    = rd_last;
        rd_fire     = pkt_rd && pkt_valid;
        slot_freed  = rd_fire && rd_last;
    end

    always_ff @(posedge clk) begin
        if (body_in) mem[waddr] <= rx_word;
        if (hdr_in)  slot_lm1[wslot] <= IDX_W'(rx_word[LEN_FW-1:0]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_body     <= 1'b0;
            left        <= '0;
            widx        <= '0;
            ridx        <= '0;
            wslot       <= '0;
            rslot       <= '0;
            occ         <= '0;
            ctl_valid   <= 1'b0;
            ctl_payload <= '0;
        end else begin
            ctl_valid <= ctl_in;
            if (ctl_in) ctl_payload <= rx_word[29:0];

            if (hdr_in) begin
                in_body <= 1'b1;
                left    <= LEFT_W'(rx_word[LEN_FW-1:0]) + LEFT_W'(1);
                widx    <= '0;
            end else if (body_in) begin
                widx <= widx + 1'b1;
                left <= left - 1'b1;
                if (wr_done) begin
                    in_body <= 1'b0;
                    wslot   <= next_slot(wslot);
                end
            end

            if (rd_fire) begin
                if (rd_last) begin
                    ridx  <= '0;
                    rslot <= next_slot(rslot);
                end else begin
                    ridx <= ridx + 1'b1;
                end
            end

            occ <= occ + OCC_W'(wr_done) - OCC_W'(slot_freed);
        end
    end

    AST_RX_ROOM: assert property (@(posedge clk) disable iff (rst)
        hdr_in |-> (occ < OCC_W'(DEPTH)));                          // R9
    AST_RX_OCC_CAP: assert property (@(posedge clk) disable iff (rst)
        occ <= OCC_W'(DEPTH));                                      // R8
    AST_CTL_FROM_LINK: assert property (@(posedge clk) disable iff (rst)
        ctl_valid |-> $past(rx_valid));                             // R10

endmodule

// File: rtl/lcc_tx_arb.sv
module lcc_tx_arb
    import lcc_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int MAXW  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              credit_seen,
    input  logic              slot_freed,
    input  logic              ctl_in_valid,
    input  logic [29:0]       ctl_in_payload,
    output logic              ctl_in_ready,
    input  logic              tx_dat_valid,
    input  logic [LEN_FW-1:0] tx_dat_lm1,
    input  logic [31:0]       tx_dat_word,
    output logic              tx_dat_ready,
    output logic              link_valid,
    output logic [31:0]       link_word
);
    localparam int CNT_W  = $clog2(DEPTH + 1);
    localparam int LEFT_W = $clog2(MAXW + 1);

    logic [CNT_W-1:0]  credits, pending;
    logic              in_body;
    logic [LEFT_W-1:0] left;
    link_beat_t        beat_q, beat_d;
    logic              pick_credit, pick_ctl, pick_hdr, body_fire;

    always_comb begin
        tx_dat_ready = in_body;
        ctl_in_ready = !in_body && (pending == '0);
        pick_credit  = !in_body && (pending != '0);
        pick_ctl     = ctl_in_ready && ctl_in_valid;
        pick_hdr     = ctl_in_ready && !ctl_in_valid && tx_dat_valid && (credits != '0);
        body_fire    = in_body && tx_dat_valid;

        beat_d = '0;
        if (in_body) begin
            beat_d.valid = tx_dat_valid;
            beat_d.word  = tx_dat_word;
        end else if (pick_credit) begin
            beat_d.valid = 1'b1;
            beat_d.word  = make_credit();
        end else if (pick_ctl) begin
            beat_d.valid = 1'b1;
            beat_d.word  = make_ctrl(ctl_in_payload);
        end else if (pick_hdr) begin
            beat_d.valid = 1'b1;
            beat_d.word  = make_hdr(tx_dat_lm1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            credits <= CNT_W'(DEPTH);
            pending <= '0;
            in_body <= 1'b0;
            left    <= '0;
            beat_q  <= '0;
        end else begin
            beat_q <= beat_d;

            case ({credit_seen, pick_hdr})
                2'b10:   if (credits != CNT_W'(DEPTH)) credits <= credits + 1'b1;
                2'b01:   credits <= credits - 1'b1;
                default: credits <= credits;
            endcase

            pending <= pending + CNT_W'(slot_freed) - CNT_W'(pick_credit);

            if (pick_hdr) begin
                in_body <= 1'b1;
                left    <= LEFT_W'(tx_dat_lm1) + LEFT_W'(1);
            end else if (body_fire) begin
                left <= left - 1'b1;
                if (left == LEFT_W'(1)) in_body <= 1'b0;
            end
        end
    end

    assign link_valid = beat_q.valid;
    assign link_word  = beat_q.word;

    AST_CREDIT_CAP: assert property (@(posedge clk) disable iff (rst)
        credits <= CNT_W'(DEPTH));                                  // R4
    AST_HDR_SPENDS: assert property (@(posedge clk) disable iff (rst)
        (pick_hdr && !credit_seen) |=> (credits == $past(credits) - 1'b1)); // R3
    AST_BODY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (in_body && !(body_fire && left == LEFT_W'(1))) |=> in_body); // R6
    AST_CREDIT_FIRST: assert property (@(posedge clk) disable iff (rst)
        (!in_body && pending != '0) |=> (link_valid && link_word == make_credit())); // R5
    AST_PENDING_CAP: assert property (@(posedge clk) disable iff (rst)
        pending <= CNT_W'(DEPTH));                                  // R9

endmodule

// File: rtl/link_credit_ctrl.sv
module link_credit_ctrl
    import lcc_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int MAXW  = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        rx_valid,
    input  logic [31:0] rx_word,
    output logic        link_valid,
    output logic [31:0] link_word,
    input  logic        tx_dat_valid,
    input  logic [3:0]  tx_dat_lm1,
    input  logic [31:0] tx_dat_word,
    output logic        tx_dat_ready,
    input  logic        ctl_in_valid,
    input  logic [29:0] ctl_in_payload,
    output logic        ctl_in_ready,
    output logic        ctl_rx_valid,
    output logic [29:0] ctl_rx_payload,
    output logic        pkt_valid,
    output logic [31:0] pkt_word,
    output logic        pkt_last,
    input  logic        pkt_rd
);
    logic credit_seen, slot_freed;

    lcc_rx_store #(.DEPTH(DEPTH), .MAXW(MAXW)) u_rx (
        .clk         (clk),
        .rst         (rst),
        .rx_valid    (rx_valid),
        .rx_word     (rx_word),
        .credit_seen (credit_seen),
        .ctl_valid   (ctl_rx_valid),
        .ctl_payload (ctl_rx_payload),
        .pkt_valid   (pkt_valid),
        .pkt_word    (pkt_word),
        .pkt_last    (pkt_last),
        .pkt_rd      (pkt_rd),
        .slot_freed  (slot_freed)
    );

    lcc_tx_arb #(.DEPTH(DEPTH), .MAXW(MAXW)) u_tx (
        .clk            (clk),
        .rst            (rst),
        .credit_seen    (credit_seen),
        .slot_freed     (slot_freed),
        .ctl_in_valid   (ctl_in_valid),
        .ctl_in_payload (ctl_in_payload),
        .ctl_in_ready   (ctl_in_ready),
        .tx_dat_valid   (tx_dat_valid),
        .tx_dat_lm1     (tx_dat_lm1),
        .tx_dat_word    (tx_dat_word),
        .tx_dat_ready   (tx_dat_ready),
        .link_valid     (link_valid),
        .link_word      (link_word)
    );

endmodule

// File: tb/tb_link_credit_ctrl.sv
module tb_link_credit_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 2;
    localparam logic [31:0] CREDIT_W = 32'h4000_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_valid = 1'b0;
    logic [31:0] rx_word = '0;
    logic        link_valid;
    logic [31:0] link_word;
    logic        tx_dat_valid = 1'b0;
    logic [3:0]  tx_dat_lm1 = '0;
    logic [31:0] tx_dat_word = '0;
    logic        tx_dat_ready;
    logic        ctl_in_valid = 1'b0;
    logic [29:0] ctl_in_payload = '0;
    logic        ctl_in_ready;
    logic        ctl_rx_valid;
    logic [29:0] ctl_rx_payload;
    logic        pkt_valid;
    logic [31:0] pkt_word;
    logic        pkt_last;
    logic        pkt_rd = 1'b0;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    bit sdone;

    logic [31:0] lg [0:255];
    int lg_n = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    link_credit_ctrl #(.DEPTH(DEPTH), .MAXW(16)) dut (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_word(rx_word),
        .link_valid(link_valid), .link_word(link_word),
        .tx_dat_valid(tx_dat_valid), .tx_dat_lm1(tx_dat_lm1),
        .tx_dat_word(tx_dat_word), .tx_dat_ready(tx_dat_ready),
        .ctl_in_valid(ctl_in_valid), .ctl_in_payload(ctl_in_payload),
        .ctl_in_ready(ctl_in_ready), .ctl_rx_valid(ctl_rx_valid),
        .ctl_rx_payload(ctl_rx_payload), .pkt_valid(pkt_valid),
        .pkt_word(pkt_word), .pkt_last(pkt_last), .pkt_rd(pkt_rd)
    );

    always @(negedge clk) begin
        if (!rst && link_valid && lg_n < 256) begin
            lg[lg_n] = link_word;
            lg_n = lg_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] lg_at(input int i);
        return (i < lg_n && i >= 0) ? lg[i] : 32'hDEAD_BEEF;
    endfunction

    task automatic send_pkt(input int len, input logic [31:0] base);
        int i = 0;
        tx_dat_valid = 1'b1;
        tx_dat_lm1   = 4'(len - 1);
        while (i < len) begin
            tx_dat_word = base + 32'(i);
            if (tx_dat_ready) i++;
            @(negedge clk);
        end
        tx_dat_valid = 1'b0;
    endtask

    task automatic ctl_send(input logic [29:0] p);
        bit taken = 1'b0;
        ctl_in_valid   = 1'b1;
        ctl_in_payload = p;
        while (!taken) begin
            taken = ctl_in_ready;
            @(negedge clk);
        end
        ctl_in_valid = 1'b0;
    endtask

    task automatic rx_send(input logic [31:0] w);
        rx_valid = 1'b1;
        rx_word  = w;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic rx_send_pkt(input int len, input logic [31:0] base);
        rx_send({2'b00, 26'd0, 4'(len - 1)});
        for (int i = 0; i < len; i++) rx_send(base + 32'(i));
    endtask

    task automatic read_expect(input logic [31:0] exp, input bit last, input string req);
        chk(pkt_valid == 1'b1, req, 32'(pkt_valid), 32'd1);
        chk(pkt_word == exp, req, pkt_word, exp);
        chk(pkt_last == last, req, 32'(pkt_last), 32'(last));
        pkt_rd = 1'b1;
        @(negedge clk);
        pkt_rd = 1'b0;
    endtask

    task automatic wait_sdone();
        int t = 0;
        while (!sdone && t < 300) begin
            @(negedge clk);
            t++;
        end
        chk(sdone, "R3 sender completion", 32'(sdone), 32'd1);
    endtask

    task automatic t_reset();
        chk(link_valid == 1'b0, "R1 link idle", 32'(link_valid), 32'd0);
        chk(pkt_valid == 1'b0, "R1 buffer empty", 32'(pkt_valid), 32'd0);
        chk(ctl_rx_valid == 1'b0, "R1 no ctl strobe", 32'(ctl_rx_valid), 32'd0);
        chk(tx_dat_ready == 1'b0, "R1 no body", 32'(tx_dat_ready), 32'd0);
        chk(ctl_in_ready == 1'b1, "R1 ctl ready", 32'(ctl_in_ready), 32'd1);
    endtask

    task automatic t_basic_send();
        int m = lg_n;
        send_pkt(3, 32'h100);
        cyc(2);
        chk(lg_n - m == 4, "R2 packet word count", 32'(lg_n - m), 32'd4);
        chk(lg_at(m) == 32'h0000_0002, "R2 header format", lg_at(m), 32'h2);
        for (int i = 0; i < 3; i++)
            chk(lg_at(m + 1 + i) == 32'h100 + 32'(i), "R2 payload", lg_at(m + 1 + i), 32'h100 + 32'(i));
    endtask

    task automatic t_credit_stall();
        int m;
        send_pkt(1, 32'h200);
        cyc(2);
        m = lg_n;
        sdone = 1'b0;
        fork begin send_pkt(2, 32'h300); sdone = 1'b1; end join_none
        cyc(10);
        chk(lg_n == m, "R3 stall at zero credit", 32'(lg_n - m), 32'd0);
        rx_send(CREDIT_W);
        wait_sdone();
        cyc(2);
        chk(lg_at(m) == 32'h0000_0001, "R3 resumes after credit", lg_at(m), 32'h1);
        chk(lg_at(m + 2) == 32'h301, "R3 resumed payload", lg_at(m + 2), 32'h301);
    endtask

    task automatic t_saturate();
        int m;
        for (int i = 0; i < 4; i++) rx_send(CREDIT_W);
        m = lg_n;
        sdone = 1'b0;
        fork begin
            send_pkt(1, 32'h400); send_pkt(1, 32'h401); send_pkt(1, 32'h402); sdone = 1'b1;
        end join_none
        cyc(20);
        chk(lg_n - m == 4, "R4 budget capped at DEPTH", 32'(lg_n - m), 32'd4);
        rx_send(CREDIT_W);
        wait_sdone();
        cyc(2);
        chk(lg_n - m == 6, "R4 third packet after credit", 32'(lg_n - m), 32'd6);
        chk(lg_at(m + 5) == 32'h402, "R4 third payload", lg_at(m + 5), 32'h402);
    endtask

    task automatic t_ctl_priority();
        int m, m2;
        sdone = 1'b0;
        fork begin send_pkt(1, 32'h500); sdone = 1'b1; end join_none
        cyc(2);
        m = lg_n;
        ctl_send(30'h1234);
        cyc(3);
        chk(lg_at(m) == 32'h8000_1234, "R7 control passes blocked data", lg_at(m), 32'h8000_1234);
        rx_send_pkt(1, 32'h600);
        cyc(1);
        m2 = lg_n;
        read_expect(32'h600, 1'b1, "R8 single word packet");
        ctl_send(30'h55);
        cyc(3);
        chk(lg_at(m2) == CREDIT_W, "R5 credit before control", lg_at(m2), CREDIT_W);
        chk(lg_at(m2 + 1) == 32'h8000_0055, "R5 control after credit", lg_at(m2 + 1), 32'h8000_0055);
        rx_send(CREDIT_W);
        wait_sdone();
        cyc(2);
    endtask

    task automatic t_rx_order();
        int m;
        rx_send_pkt(2, 32'h700);
        rx_send_pkt(1, 32'h800);
        cyc(2);
        m = lg_n;
        read_expect(32'h700, 1'b0, "R8 first word");
        cyc(3);
        chk(lg_n == m, "R9 no credit before last word", 32'(lg_n - m), 32'd0);
        read_expect(32'h701, 1'b1, "R8 last word");
        cyc(3);
        chk(lg_n - m == 1, "R9 one credit per slot", 32'(lg_n - m), 32'd1);
        chk(lg_at(m) == CREDIT_W, "R9 credit word", lg_at(m), CREDIT_W);
        read_expect(32'h800, 1'b1, "R8 second packet order");
        cyc(3);
        chk(lg_n - m == 2, "R9 second credit", 32'(lg_n - m), 32'd2);
        chk(pkt_valid == 1'b0, "R8 buffer drained", 32'(pkt_valid), 32'd0);
    endtask

    task automatic t_rx_ctl();
        rx_valid = 1'b1;
        rx_word  = 32'h8000_0ABC;
        @(negedge clk);
        rx_valid = 1'b0;
        chk(ctl_rx_valid == 1'b1, "R10 ctl strobe", 32'(ctl_rx_valid), 32'd1);
        chk(ctl_rx_payload == 30'h0ABC, "R10 ctl payload", 32'(ctl_rx_payload), 32'hABC);
        @(negedge clk);
        chk(ctl_rx_valid == 1'b0, "R10 single cycle strobe", 32'(ctl_rx_valid), 32'd0);
        chk(pkt_valid == 1'b0, "R10 ctl not buffered", 32'(pkt_valid), 32'd0);
        rx_send(CREDIT_W);
        cyc(1);
        chk(pkt_valid == 1'b0, "R10 credit not buffered", 32'(pkt_valid), 32'd0);
    endtask

    task automatic t_no_interrupt();
        int m = lg_n;
        int t = 0;
        sdone = 1'b0;
        fork begin send_pkt(4, 32'h900); sdone = 1'b1; end join_none
        while (!tx_dat_ready && t < 50) begin @(negedge clk); t++; end
        ctl_send(30'h77);
        wait_sdone();
        cyc(3);
        chk(lg_at(m) == 32'h0000_0003, "R6 header", lg_at(m), 32'h3);
        chk(lg_at(m + 4) == 32'h903, "R6 body complete", lg_at(m + 4), 32'h903);
        chk(lg_at(m + 5) == 32'h8000_0077, "R6 control after body", lg_at(m + 5), 32'h8000_0077);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic_send();
        t_credit_stall();
        t_saturate();
        t_ctl_priority();
        t_rx_order();
        t_rx_ctl();
        t_no_interrupt();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule